// File: doc/BRIEF.md
# Bus-Master DMA Address and Count Engine

This block keeps track of where two bus-master data streams are and how much of each is left. The read channel moves data from the system bus into local storage. The write channel moves data from local storage out to the bus. Each channel has a next-address register and a remaining-byte-count register. A beat interface reports every word that completes, and each channel updates its two registers when one of its words completes.

One shared enable bit decides whether the byte counts limit the transfers. With counts enabled, a channel stops when its count reaches zero and raises its completion flag. The final word may carry only 1 to 3 bytes. With counts disabled, a channel runs until software stops it.

An interrupt register holds four sticky flags: read done, write done, master abort and target abort. Writing a one to a flag clears it. Software programs all registers through a simple register port, one write per cycle. Reads from the register port are combinational.

Top module: `dma_busmaster`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, and both channels are inactive.
- R2: Address writes (register 0 = read channel, register 2 = write channel) store the value with bits 1:0 forced to zero.
- R3: Each completed, non-aborted beat on an active channel advances that channel's address by 4. `beat_dir` = 1 selects the read channel and 0 selects the write channel.
- R4: With counts enabled, the bytes of the next beat (`*_bytes`) are the smaller of 4 and the remaining count. Each beat lowers the count (register 1 = read, register 3 = write) by that number.
- R5: With counts enabled, the beat that brings a count to zero clears that channel's run bit and makes the channel inactive. It also sets the channel's done flag: INT bit 19 for read, bit 18 for write.
- R6: With counts disabled (CTRL bit 0 = 0), a running channel stays active whatever its count, moves 4 bytes per beat, and leaves its count register unchanged.
- R7: CTRL bit 0 is one count enable shared by both channels. CTRL bit 1 runs the read channel and bit 2 runs the write channel. CTRL reads back the live run bits.
- R8: In the INT register (register 5), writing a one to any of bits 21:18 clears that flag. Writing a zero leaves the flag as it was.
- R9: `irq` is the OR of every set flag whose interrupt is enabled. INT bit 0 enables read done and bit 1 enables write done. If either of those is set, the master-abort flag (bit 20) and the target-abort flag (bit 21) are enabled as well.
- R10: A beat with `beat_mabort` or `beat_tabort` on an active channel sets INT bit 20 or bit 21. It stops that channel and leaves its address and count unchanged. Writing the run bit again restarts the channel.
- R11: A beat aimed at an inactive channel has no effect on any register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| beat_valid | input | 1 | A beat completed or aborted this cycle |
| beat_dir | input | 1 | 1 = read channel, 0 = write channel |
| beat_mabort | input | 1 | Beat ended in a master abort |
| beat_tabort | input | 1 | Beat ended in a target abort |
| rd_active | output | 1 | Read channel wants to move data |
| rd_addr | output | 32 | Next read address |
| rd_bytes | output | 3 | Bytes in the next read beat (1..4) |
| wr_active | output | 1 | Write channel wants to move data |
| wr_addr | output | 32 | Next write address |
| wr_bytes | output | 3 | Bytes in the next write beat (1..4) |
| irq | output | 1 | Interrupt request |

## Verification
The count-limited run uses a count of 10. This forces two full words followed by a 2-byte tail, so it can tell a decrement by the bytes actually moved from a fixed decrement of 4. It also tests the exact point at which the channel stops. A count-disabled run starts at zero and then reprograms the count. This shows that the count is ignored in that mode, rather than wrapping or stopping the channel. Both channels then run together under the shared enable with different counts (3 and 5), which separates per-channel state from shared state. Aborts on each direction, with the completion interrupts enabled and then disabled, tell the automatic arming of the abort interrupts apart from the channel-stop behaviour.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [2:0] {
        REG_RD_ADDR = 3'd0,
        REG_RD_CNT  = 3'd1,
        REG_WR_ADDR = 3'd2,
        REG_WR_CNT  = 3'd3,
        REG_CTRL    = 3'd4,
        REG_INT     = 3'd5
    } reg_sel_e;

    localparam int CTRL_CNT_EN = 0;
    localparam int CTRL_RD_RUN = 1;
    localparam int CTRL_WR_RUN = 2;

    localparam int INT_RD_IE   = 0;
    localparam int INT_WR_IE   = 1;
    localparam int ST_LSB      = 18;  // flags occupy 21:18
    localparam int N_FLAGS     = 4;

    // flag index within the 4-bit flag vector
    localparam int FL_WR_DONE  = 0;
    localparam int FL_RD_DONE  = 1;
    localparam int FL_MABORT   = 2;
    localparam int FL_TABORT   = 3;

    localparam int CH_WR       = 0;
    localparam int CH_RD       = 1;
    localparam int N_CH        = 2;
endpackage

// File: rtl/dma_chan.sv
module dma_chan #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              run_wr,
    input  logic              run_val,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:2] addr_data,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_data,
    input  logic              beat_ok,
    input  logic              beat_abort,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              run_o,
    output logic              active_o,
    output logic [2:0]        bytes_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
    localparam logic [CNT_W-1:0]  FULL_WORD = CNT_W'(4);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              run;
    } chan_t;

    chan_t st_q, st_d;
    logic  active;
    logic  [2:0] bytes;
    logic  done;

    always_comb begin
        st_d   = st_q;
        done   = 1'b0;
        active = st_q.run && (!cnt_en || st_q.cnt != '0);
        bytes  = (!cnt_en || st_q.cnt >= FULL_WORD) ? 3'd4 : {1'b0, st_q.cnt[1:0]};
        if (active && beat_ok) begin
            st_d.addr = st_q.addr + WORD_STEP;
            if (cnt_en) begin
                st_d.cnt = st_q.cnt - CNT_W'(bytes);
                if (st_q.cnt == CNT_W'(bytes)) begin
                    st_d.run = 1'b0;
                    done     = 1'b1;
                end
            end
        end
        if (active && beat_abort) st_d.run = 1'b0;
        if (addr_wr) st_d.addr = {addr_data, 2'b00};
        if (cnt_wr)  st_d.cnt  = cnt_data;
        if (run_wr)  st_d.run  = run_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o   = st_q.addr;
    assign cnt_o    = st_q.cnt;
    assign run_o    = st_q.run;
    assign active_o = active;
    assign bytes_o  = bytes;
    assign done_o   = done;

    a_r2_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.addr[1:0] == 2'b00);
    a_r4_bytes_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bytes_o != 3'd0 && bytes_o <= 3'd4));
    a_r5_idle_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt_o == '0) |-> !active_o);
    a_r5_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!run_o || $past(run_wr)));
    a_r6_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_wr) |=> cnt_o == $past(cnt_o));
    a_r11_idle_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !addr_wr) |=> addr_o == $past(addr_o));
endmodule

// File: rtl/dma_irq.sv
module dma_irq #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          int_wr,
    input  logic [1:0]    ie_val,
    input  logic [NF-1:0] clr_mask,
    input  logic [NF-1:0] set_ev,
    output logic [NF-1:0] flags_o,
    output logic [1:0]    ie_o,
    output logic          irq_o
);
    import dma_pkg::*;

    typedef struct packed {
        logic [NF-1:0] flags;
        logic [1:0]    ie;
    } irq_t;

    irq_t st_q, st_d;
    logic [NF-1:0] en_mask;
    logic          armed;

    always_comb begin
        st_d  = st_q;
        armed = |st_q.ie;
        en_mask = '0;
        en_mask[FL_RD_DONE] = st_q.ie[INT_RD_IE];
        en_mask[FL_WR_DONE] = st_q.ie[INT_WR_IE];
        en_mask[FL_MABORT]  = armed;
        en_mask[FL_TABORT]  = armed;
        if (int_wr) begin
            st_d.ie    = ie_val;
            st_d.flags = st_q.flags & ~clr_mask;
        end
        st_d.flags = st_d.flags | set_ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign ie_o    = st_q.ie;
    assign irq_o   = |(st_q.flags & en_mask);

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|flags_o && |ie_o));
    a_r8_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_ev) |=> ((flags_o & $past(set_ev)) == $past(set_ev)));
    a_r8_no_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_wr) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

// File: rtl/dma_busmaster.sv
module dma_busmaster #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              beat_valid,
    input  logic              beat_dir,
    input  logic              beat_mabort,
    input  logic              beat_tabort,
    output logic              rd_active,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [2:0]        rd_bytes,
    output logic              wr_active,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [2:0]        wr_bytes,
    output logic              irq
);
    import dma_pkg::*;

    typedef struct packed {
        logic cnt_en;
    } ctrl_t;

    ctrl_t ctrl_q, ctrl_d;

    logic              ctrl_wr, int_wr, abort_in;
    logic [N_CH-1:0]   addr_wr, cnt_wr, run_val, beat_ok, beat_ab;
    logic [N_CH-1:0]   run, active, done;
    logic [ADDR_W-1:0] ch_addr  [N_CH];
    logic [CNT_W-1:0]  ch_cnt   [N_CH];
    logic [2:0]        ch_bytes [N_CH];
    logic [N_FLAGS-1:0] set_ev, flags;
    logic [1:0]        ie;
    logic              abort_taken;
    logic              unused_wdata;

    assign ctrl_wr  = reg_wr && (reg_addr == REG_CTRL);
    assign int_wr   = reg_wr && (reg_addr == REG_INT);
    assign abort_in = beat_mabort | beat_tabort;

    assign addr_wr[CH_RD] = reg_wr && (reg_addr == REG_RD_ADDR);
    assign addr_wr[CH_WR] = reg_wr && (reg_addr == REG_WR_ADDR);
    assign cnt_wr[CH_RD]  = reg_wr && (reg_addr == REG_RD_CNT);
    assign cnt_wr[CH_WR]  = reg_wr && (reg_addr == REG_WR_CNT);
    assign run_val[CH_RD] = reg_wdata[CTRL_RD_RUN];
    assign run_val[CH_WR] = reg_wdata[CTRL_WR_RUN];

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) ctrl_d.cnt_en = reg_wdata[CTRL_CNT_EN];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        logic dir_hit;
        assign dir_hit    = beat_valid && (beat_dir == 1'(g));
        assign beat_ok[g] = dir_hit && !abort_in;
        assign beat_ab[g] = dir_hit && abort_in;

        dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_en    (ctrl_q.cnt_en),
            .run_wr    (ctrl_wr),
            .run_val   (run_val[g]),
            .addr_wr   (addr_wr[g]),
            .addr_data (reg_wdata[ADDR_W-1:2]),
            .cnt_wr    (cnt_wr[g]),
            .cnt_data  (reg_wdata[CNT_W-1:0]),
            .beat_ok   (beat_ok[g]),
            .beat_abort(beat_ab[g]),
            .addr_o    (ch_addr[g]),
            .cnt_o     (ch_cnt[g]),
            .run_o     (run[g]),
            .active_o  (active[g]),
            .bytes_o   (ch_bytes[g]),
            .done_o    (done[g])
        );
    end

    assign abort_taken         = |(beat_ab & active);
    assign set_ev[FL_WR_DONE]  = done[CH_WR];
    assign set_ev[FL_RD_DONE]  = done[CH_RD];
    assign set_ev[FL_MABORT]   = abort_taken && beat_mabort;
    assign set_ev[FL_TABORT]   = abort_taken && beat_tabort;

    dma_irq #(.NF(N_FLAGS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .int_wr  (int_wr),
        .ie_val  (reg_wdata[1:0]),
        .clr_mask(reg_wdata[ST_LSB+N_FLAGS-1:ST_LSB]),
        .set_ev  (set_ev),
        .flags_o (flags),
        .ie_o    (ie),
        .irq_o   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_RD_ADDR: reg_rdata = 32'(ch_addr[CH_RD]);
            REG_RD_CNT:  reg_rdata = 32'(ch_cnt[CH_RD]);
            REG_WR_ADDR: reg_rdata = 32'(ch_addr[CH_WR]);
            REG_WR_CNT:  reg_rdata = 32'(ch_cnt[CH_WR]);
            REG_CTRL: begin
                reg_rdata[CTRL_CNT_EN] = ctrl_q.cnt_en;
                reg_rdata[CTRL_RD_RUN] = run[CH_RD];
                reg_rdata[CTRL_WR_RUN] = run[CH_WR];
            end
            REG_INT: begin
                reg_rdata[1:0] = ie;
                reg_rdata[ST_LSB+N_FLAGS-1:ST_LSB] = flags;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign unused_wdata = ^reg_wdata;

    assign rd_active = active[CH_RD];
    assign rd_addr   = ch_addr[CH_RD];
    assign rd_bytes  = ch_bytes[CH_RD];
    assign wr_active = active[CH_WR];
    assign wr_addr   = ch_addr[CH_WR];
    assign wr_bytes  = ch_bytes[CH_WR];

    a_r10_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_taken && !ctrl_wr) |=> !(|(run & $past(beat_ab & active))));
    a_r10_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_taken && beat_mabort) |=> flags[FL_MABORT]);
endmodule

// File: tb/dma_busmaster_tb.sv
module dma_busmaster_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        beat_valid = 1'b0, beat_dir = 1'b0, beat_mabort = 1'b0, beat_tabort = 1'b0;
    logic        rd_active, wr_active, irq;
    logic [31:0] rd_addr, wr_addr;
    logic [2:0]  rd_bytes, wr_bytes;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    dma_busmaster u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_valid(beat_valid),
        .beat_dir(beat_dir), .beat_mabort(beat_mabort), .beat_tabort(beat_tabort),
        .rd_active(rd_active), .rd_addr(rd_addr), .rd_bytes(rd_bytes),
        .wr_active(wr_active), .wr_addr(wr_addr), .wr_bytes(wr_bytes), .irq(irq)
    );

    localparam logic [2:0] A_RA = 3'd0, A_RC = 3'd1, A_WA = 3'd2, A_WC = 3'd3,
                           A_CT = 3'd4, A_IN = 3'd5;
    localparam logic [31:0] F_WD = 32'h1 << 18, F_RD = 32'h1 << 19,
                            F_MA = 32'h1 << 20, F_TA = 32'h1 << 21;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic beat(input logic dir, input logic ma, input logic ta);
        @(negedge clk);
        beat_valid = 1'b1; beat_dir = dir; beat_mabort = ma; beat_tabort = ta;
        @(posedge clk);
        @(negedge clk);
        beat_valid = 1'b0; beat_mabort = 1'b0; beat_tabort = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 6; i++) rd_chk("R1 reg after reset", 3'(i), 32'h0);
        check("R1 irq", 32'(irq), 0);
        check("R1 rd_active", 32'(rd_active), 0);
        check("R1 wr_active", 32'(wr_active), 0);
    endtask

    task automatic t_align();
        wr_reg(A_RA, 32'h0000_1003);
        rd_chk("R2 rd addr aligned", A_RA, 32'h0000_1000);
        wr_reg(A_WA, 32'hFFFF_FFFE);
        rd_chk("R2 wr addr aligned", A_WA, 32'hFFFF_FFFC);
    endtask

    task automatic t_counted();
        wr_reg(A_IN, 32'h1);
        wr_reg(A_RA, 32'h100);
        wr_reg(A_RC, 32'd10);
        wr_reg(A_CT, 32'h3);
        check("R4 rd_active", 32'(rd_active), 1);
        check("R4 rd_bytes full", 32'(rd_bytes), 4);
        beat(1'b1, 1'b0, 1'b0);
        check("R3 addr +4", rd_addr, 32'h104);
        rd_chk("R4 cnt 6", A_RC, 32'd6);
        beat(1'b1, 1'b0, 1'b0);
        rd_chk("R4 cnt 2", A_RC, 32'd2);
        check("R4 tail bytes", 32'(rd_bytes), 2);
        beat(1'b1, 1'b0, 1'b0);
        check("R3 addr after tail", rd_addr, 32'h10C);
        rd_chk("R5 cnt zero", A_RC, 32'd0);
        check("R5 inactive", 32'(rd_active), 0);
        rd_chk("R5 run cleared", A_CT, 32'h1);
        rd_chk("R5 rd done flag", A_IN, F_RD | 32'h1);
        check("R9 irq rd done", 32'(irq), 1);
        wr_reg(A_IN, 32'h1);
        rd_chk("R8 zero keeps flag", A_IN, F_RD | 32'h1);
        wr_reg(A_IN, F_RD | 32'h1);
        rd_chk("R8 one clears", A_IN, 32'h1);
        check("R9 irq low after clear", 32'(irq), 0);
    endtask

    task automatic t_uncounted();
        wr_reg(A_CT, 32'h0);
        wr_reg(A_WA, 32'h200);
        wr_reg(A_WC, 32'h0);
        wr_reg(A_CT, 32'h4);
        check("R6 active at count 0", 32'(wr_active), 1);
        check("R6 bytes 4", 32'(wr_bytes), 4);
        for (int i = 0; i < 3; i++) beat(1'b0, 1'b0, 1'b0);
        check("R6 addr", wr_addr, 32'h20C);
        rd_chk("R6 cnt unchanged", A_WC, 32'h0);
        check("R6 still active", 32'(wr_active), 1);
        wr_reg(A_WC, 32'd5);
        beat(1'b0, 1'b0, 1'b0);
        rd_chk("R6 cnt ignored", A_WC, 32'd5);
        check("R3 wr addr", wr_addr, 32'h210);
    endtask

    task automatic t_shared();
        wr_reg(A_RA, 32'h400);
        wr_reg(A_RC, 32'd3);
        wr_reg(A_IN, 32'h2);
        wr_reg(A_CT, 32'h7);
        check("R7 rd bytes limited", 32'(rd_bytes), 3);
        check("R7 wr bytes", 32'(wr_bytes), 4);
        beat(1'b0, 1'b0, 1'b0);
        rd_chk("R7 wr cnt 1", A_WC, 32'd1);
        check("R4 wr bytes 1", 32'(wr_bytes), 1);
        beat(1'b0, 1'b0, 1'b0);
        check("R5 wr inactive", 32'(wr_active), 0);
        rd_chk("R5 wr done flag", A_IN, F_WD | 32'h2);
        check("R9 irq wr done", 32'(irq), 1);
        check("R7 rd unaffected", 32'(rd_active), 1);
        beat(1'b1, 1'b0, 1'b0);
        rd_chk("R5 both flags", A_IN, F_WD | F_RD | 32'h2);
        check("R3 rd addr", rd_addr, 32'h404);
        wr_reg(A_IN, 32'h003C_0000);
        rd_chk("R8 clear all", A_IN, 32'h0);
        check("R9 irq off", 32'(irq), 0);
    endtask

    task automatic t_abort();
        wr_reg(A_IN, 32'h1);
        wr_reg(A_RA, 32'h300);
        wr_reg(A_RC, 32'd8);
        wr_reg(A_CT, 32'h3);
        beat(1'b1, 1'b1, 1'b0);
        check("R10 rd stopped", 32'(rd_active), 0);
        check("R10 addr held", rd_addr, 32'h300);
        rd_chk("R10 cnt held", A_RC, 32'd8);
        rd_chk("R10 mabort flag", A_IN, F_MA | 32'h1);
        check("R9 abort armed by rd ie", 32'(irq), 1);
        wr_reg(A_CT, 32'h3);
        check("R10 restart", 32'(rd_active), 1);
        wr_reg(A_IN, F_MA);
        check("R9 irq off", 32'(irq), 0);
        wr_reg(A_WA, 32'h500);
        wr_reg(A_WC, 32'd8);
        wr_reg(A_CT, 32'h5);
        beat(1'b0, 1'b0, 1'b1);
        rd_chk("R10 tabort flag", A_IN, F_TA);
        check("R9 not armed", 32'(irq), 0);
        wr_reg(A_IN, 32'h2);
        check("R9 armed by wr ie", 32'(irq), 1);
        check("R10 wr addr held", wr_addr, 32'h500);
    endtask

    task automatic t_ignore();
        beat(1'b1, 1'b0, 1'b0);
        check("R11 rd addr", rd_addr, 32'h300);
        rd_chk("R11 rd cnt", A_RC, 32'd8);
        beat(1'b1, 1'b1, 1'b0);
        rd_chk("R11 no abort flag", A_IN, F_TA | 32'h2);
        beat(1'b0, 1'b0, 1'b0);
        check("R11 wr addr", wr_addr, 32'h500);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_align();
        t_counted();
        t_uncounted();
        t_shared();
        t_abort();
        t_ignore();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule